// File: doc/BRIEF.md
# Miss Target Queue with Upgrade Rewrite

This block collects the requests that are waiting on one outstanding cache miss. Each request becomes an entry holding a command code, a source tag, a 16-bit order stamp, a 32-bit ready time and a marked-pending bit. Entries leave in arrival order. The queue also keeps two summary flags:

- a needs-exclusive flag, set when any pushed request wants an exclusive copy;
- a has-upgrade flag, set when any pushed request is an upgrade.

Requests that come from a snoop never touch either flag.

Besides push and pop, the queue has three control operations:

- A flag reset clears both summary flags.
- A rewrite sequencer walks the queue one entry per cycle and turns every upgrade command into a read-exclusive command. This is used once another agent has invalidated the line, so an upgrade can no longer succeed.
- A pending-release sequencer walks the queue one entry per cycle. For each entry whose marked-pending bit is set, it emits a one-cycle pulse carrying that entry's order stamp, which tells the upstream requester that its request has been accepted downstream.

While either walk is running, push and pop requests are dropped.

Top module: `miss_target_queue`

## Requirements
- R1: A push whose source is not a snoop sets `needsExcl` from the next cycle if its command wants exclusive ownership. The commands that want it are read-exclusive (1), upgrade (2) and write (3). Read (0) and prefetch (4) leave the flag as it was. Source codes are CPU 0, snoop 1 and prefetcher 2.
- R2: A push of an upgrade command (2) whose source is not a snoop sets `hasUpgrade` from the next cycle.
- R3: A snoop-sourced push (source 1) is stored like any other entry but leaves `needsExcl` and `hasUpgrade` unchanged.
- R4: `flagReset` clears both summary flags in the next cycle. It overrides any flag set by a push in the same cycle.
- R5: Entries leave in push order. The head ports show the oldest entry with its command, source, order stamp, ready time and mark exactly as pushed, except for rewritten commands (R8). `headValid` is high whenever `count` is non-zero.
- R6: The queue holds at most DEPTH entries. A push into a full queue is refused and raises `overflowErr` for one cycle, and a pop in that same cycle still proceeds. A pop of an empty queue is ignored.
- R7: Raising `rewriteStart` when `hasUpgrade` is clear, or when the queue is empty, changes no entry, keeps `scanBusy` low and pulses `scanDone` in the next cycle.
- R8: Raising `rewriteStart` when `hasUpgrade` is set and the queue is not empty does the following:
  - It holds `scanBusy` high for one cycle per entry.
  - It changes every upgrade (2) into read-exclusive (1) and leaves all other fields and entries untouched.
  - It pulses `scanDone` after the last entry and clears `hasUpgrade` at that point.
- R9: `pendScanStart` visits the entries from the head onward, one per cycle. For every marked entry, and only those, it produces one `clearPendValid` pulse carrying that entry's order stamp. `scanDone` rises together with the last visit, or in the next cycle if the queue is empty.
- R10: While `scanBusy` is high, push, pop and further start requests are ignored. A push or pop in the same cycle as an accepted start is also ignored. If both starts arrive together, the rewrite wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Push request |
| pushCmd | input | 3 | Command code of the pushed entry |
| pushSrc | input | 2 | Source tag of the pushed entry |
| pushOrder | input | 16 | Order stamp of the pushed entry |
| pushReady | input | 32 | Ready time of the pushed entry |
| pushMark | input | 1 | Marked-pending bit of the pushed entry |
| popValid | input | 1 | Pop request |
| flagReset | input | 1 | Clear both summary flags |
| rewriteStart | input | 1 | Start the upgrade rewrite walk |
| pendScanStart | input | 1 | Start the pending-release walk |
| headValid | output | 1 | Queue not empty |
| headCmd | output | 3 | Command at the head |
| headSrc | output | 2 | Source at the head |
| headOrder | output | 16 | Order stamp at the head |
| headReady | output | 32 | Ready time at the head |
| headMark | output | 1 | Marked-pending bit at the head |
| count | output | CNT_W | Number of stored entries |
| needsExcl | output | 1 | Some non-snoop entry wants exclusive ownership |
| hasUpgrade | output | 1 | Some non-snoop upgrade entry is present |
| scanBusy | output | 1 | A walk is in progress |
| scanDone | output | 1 | One-cycle end-of-walk strobe |
| clearPendValid | output | 1 | Pending-release pulse |
| clearPendOrder | output | 16 | Order stamp of the released entry |
| overflowErr | output | 1 | A push was refused because the queue was full |

## Verification
The assertions check the following on every cycle:

- the occupancy bound, and that an overflow error only follows a full queue;
- that snoop pushes leave the flags alone, and that flag reset wins;
- that occupancy stays frozen during a walk;
- that each rewritten upgrade slot holds a read-exclusive command while other slots stay intact;
- that release pulses appear only during a pending walk.

Only the bench scenarios can show the rest:

- that entries come back in order with every field intact;
- that the release pulses match exactly the marked entries, in order;
- that a rewrite with no upgrade present is a no-op;
- the priority between simultaneous starts, and the interaction of random push, pop, reset and walk traffic.

// File: rtl/mtq_pkg.sv
package mtq_pkg;
  localparam int ORDER_W = 16;
  localparam int READY_W = 32;

  typedef enum logic [2:0] {
    CMD_READ     = 3'd0,
    CMD_READ_EX  = 3'd1,
    CMD_UPGRADE  = 3'd2,
    CMD_WRITE    = 3'd3,
    CMD_PREFETCH = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_SNOOP = 2'd1,
    SRC_PREF  = 2'd2
  } src_e;

  typedef struct packed {
    cmd_e               cmd;
    src_e               src;
    logic [ORDER_W-1:0] order;
    logic [READY_W-1:0] ready;
    logic               mark;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic rewrEn;
  } strobe_t;

  function automatic logic wantsExcl(cmd_e c);
    return (c == CMD_READ_EX) || (c == CMD_UPGRADE) || (c == CMD_WRITE);
  endfunction
endpackage

// File: rtl/mtq_data.sv
module mtq_data
  import mtq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [PTR_W-1:0]   wrPtr,
  input  entry_t             wrEntry,
  input  logic [PTR_W-1:0]   headPtr,
  input  logic [PTR_W-1:0]   scanPtr,
  output entry_t             headEntry,
  output logic               scanMark,
  output logic [ORDER_W-1:0] scanOrder
);
  entry_t mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.wrEn) begin
      mem[wrPtr] <= wrEntry;
    end else if (strobe.rewrEn && mem[scanPtr].cmd == CMD_UPGRADE) begin
      mem[scanPtr].cmd <= CMD_READ_EX;
    end
  end

  assign headEntry = mem[headPtr];
  assign scanMark  = mem[scanPtr].mark;
  assign scanOrder = mem[scanPtr].order;

  // R8: a visited upgrade slot holds read-exclusive afterwards
  p_upg_rewritten_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rewrEn && mem[scanPtr].cmd == CMD_UPGRADE) |=> mem[$past(scanPtr)].cmd == CMD_READ_EX);

  // R8: a visited non-upgrade slot is left intact
  p_other_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rewrEn && mem[scanPtr].cmd != CMD_UPGRADE) |=> mem[$past(scanPtr)] == $past(mem[scanPtr]));
endmodule

// File: rtl/mtq_ctrl.sv
module mtq_ctrl
  import mtq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  cmd_e               pushCmd,
  input  src_e               pushSrc,
  input  logic               popValid,
  input  logic               flagReset,
  input  logic               rewriteStart,
  input  logic               pendScanStart,
  input  logic               scanMark,
  input  logic [ORDER_W-1:0] scanOrder,
  output strobe_t            strobe,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   headPtr,
  output logic [PTR_W-1:0]   scanPtr,
  output logic [CNT_W-1:0]   count,
  output logic               needsExcl,
  output logic               hasUpgrade,
  output logic               scanBusy,
  output logic               scanDone,
  output logic               clearPendValid,
  output logic [ORDER_W-1:0] clearPendOrder,
  output logic               overflowErr
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W:0]   DEPTH_S  = (PTR_W + 1)'(DEPTH);

  logic [PTR_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] countQ, idxQ;
  logic busyQ, kindRewQ, needsQ, upgQ;
  logic startReq, opsOk, full, doPush, doPop, lastVisit, upgWalk;
  logic [PTR_W:0] ptrSum;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    startReq  = !busyQ && (rewriteStart || pendScanStart);
    opsOk     = !busyQ && !startReq;
    full      = (countQ == CNT_FULL);
    doPush    = opsOk && pushValid && !full;
    doPop     = opsOk && popValid && (countQ != '0);
    lastVisit = busyQ && (idxQ == countQ - CNT_W'(1));
    upgWalk   = upgQ && (countQ != '0);
    ptrSum    = (PTR_W + 1)'(headQ) + (PTR_W + 1)'(idxQ);
    scanPtr   = (ptrSum >= DEPTH_S) ? PTR_W'(ptrSum - DEPTH_S) : PTR_W'(ptrSum);
    strobe.wrEn   = doPush;
    strobe.rewrEn = busyQ && kindRewQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0; tailQ <= '0; countQ <= '0; idxQ <= '0;
      busyQ <= 1'b0; kindRewQ <= 1'b0; needsQ <= 1'b0; upgQ <= 1'b0;
      scanDone <= 1'b0; clearPendValid <= 1'b0; clearPendOrder <= '0; overflowErr <= 1'b0;
    end else begin
      scanDone       <= 1'b0;
      clearPendValid <= 1'b0;
      overflowErr    <= opsOk && pushValid && full;
      if (doPush) tailQ <= bump(tailQ);
      if (doPop)  headQ <= bump(headQ);
      countQ <= countQ + CNT_W'(doPush) - CNT_W'(doPop);

      if (busyQ) begin
        if (!kindRewQ) begin
          clearPendValid <= scanMark;
          clearPendOrder <= scanOrder;
        end
        if (lastVisit) begin
          busyQ    <= 1'b0;
          scanDone <= 1'b1;
        end else begin
          idxQ <= idxQ + CNT_W'(1);
        end
      end else if (startReq) begin
        idxQ     <= '0;
        kindRewQ <= rewriteStart;
        if (rewriteStart ? upgWalk : (countQ != '0)) busyQ <= 1'b1;
        else scanDone <= 1'b1;
      end

      if (flagReset) begin
        needsQ <= 1'b0;
        upgQ   <= 1'b0;
      end else begin
        if (doPush && pushSrc != SRC_SNOOP) begin
          if (wantsExcl(pushCmd)) needsQ <= 1'b1;
          if (pushCmd == CMD_UPGRADE) upgQ <= 1'b1;
        end
        if (busyQ && kindRewQ && lastVisit) upgQ <= 1'b0;
        if (startReq && rewriteStart && !upgWalk) upgQ <= 1'b0;
      end
    end
  end

  assign wrPtr      = tailQ;
  assign headPtr    = headQ;
  assign count      = countQ;
  assign needsExcl  = needsQ;
  assign hasUpgrade = upgQ;
  assign scanBusy   = busyQ;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN) countQ <= CNT_FULL);

  p_ovf_when_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |-> $past(countQ) == CNT_FULL);

  p_excl_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    (doPush && pushSrc != SRC_SNOOP && wantsExcl(pushCmd) && !flagReset) |=> needsQ);

  p_snoop_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushSrc == SRC_SNOOP && !flagReset && !busyQ && !rewriteStart)
      |=> (needsQ == $past(needsQ)) && (upgQ == $past(upgQ)));

  p_flag_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    flagReset |=> !needsQ && !upgQ);

  p_upg_cleared_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && kindRewQ && lastVisit) |=> !upgQ && scanDone);

  p_pend_in_walk_r9: assert property (@(posedge clk) disable iff (!rstN)
    clearPendValid |-> $past(busyQ && !kindRewQ));

  p_busy_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> countQ == $past(countQ));
endmodule

// File: rtl/miss_target_queue.sv
module miss_target_queue
  import mtq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  logic [2:0]         pushCmd,
  input  logic [1:0]         pushSrc,
  input  logic [15:0]        pushOrder,
  input  logic [31:0]        pushReady,
  input  logic               pushMark,
  input  logic               popValid,
  input  logic               flagReset,
  input  logic               rewriteStart,
  input  logic               pendScanStart,
  output logic               headValid,
  output logic [2:0]         headCmd,
  output logic [1:0]         headSrc,
  output logic [15:0]        headOrder,
  output logic [31:0]        headReady,
  output logic               headMark,
  output logic [CNT_W-1:0]   count,
  output logic               needsExcl,
  output logic               hasUpgrade,
  output logic               scanBusy,
  output logic               scanDone,
  output logic               clearPendValid,
  output logic [15:0]        clearPendOrder,
  output logic               overflowErr
);
  strobe_t          strobe;
  logic [PTR_W-1:0] wrPtr, headPtr, scanPtr;
  entry_t           wrEntry, headEntry;
  logic             scanMark;
  logic [ORDER_W-1:0] scanOrder;

  assign wrEntry = '{cmd: cmd_e'(pushCmd), src: src_e'(pushSrc), order: pushOrder,
                     ready: pushReady, mark: pushMark};

  mtq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushCmd(cmd_e'(pushCmd)),
    .pushSrc(src_e'(pushSrc)), .popValid(popValid), .flagReset(flagReset),
    .rewriteStart(rewriteStart), .pendScanStart(pendScanStart),
    .scanMark(scanMark), .scanOrder(scanOrder), .strobe(strobe), .wrPtr(wrPtr),
    .headPtr(headPtr), .scanPtr(scanPtr), .count(count), .needsExcl(needsExcl),
    .hasUpgrade(hasUpgrade), .scanBusy(scanBusy), .scanDone(scanDone),
    .clearPendValid(clearPendValid), .clearPendOrder(clearPendOrder),
    .overflowErr(overflowErr)
  );

  mtq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr), .wrEntry(wrEntry),
    .headPtr(headPtr), .scanPtr(scanPtr), .headEntry(headEntry),
    .scanMark(scanMark), .scanOrder(scanOrder)
  );

  assign headValid = (count != '0);
  assign headCmd   = headEntry.cmd;
  assign headSrc   = headEntry.src;
  assign headOrder = headEntry.order;
  assign headReady = headEntry.ready;
  assign headMark  = headEntry.mark;
endmodule

// File: tb/miss_target_queue_tb.sv
module miss_target_queue_tb;
  import mtq_pkg::*;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rstN = 0;
  logic pushValid = 0, pushMark = 0, popValid = 0, flagReset = 0, rewriteStart = 0, pendScanStart = 0;
  logic [2:0] pushCmd = 0;
  logic [1:0] pushSrc = 0;
  logic [15:0] pushOrder = 0;
  logic [31:0] pushReady = 0;
  logic headValid, headMark, needsExcl, hasUpgrade, scanBusy, scanDone, clearPendValid, overflowErr;
  logic [2:0] headCmd;
  logic [1:0] headSrc;
  logic [15:0] headOrder, clearPendOrder;
  logic [31:0] headReady;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0;
  logic [15:0] seenOrders[$];

  always #4 clk = ~clk;

  miss_target_queue #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  entry_t mq[$];
  bit mNeeds, mUpg, mBusy, mKindRew, mDone, mCp, mOvf;
  int mIdx;
  logic [15:0] mCpOrder;

  always @(posedge clk) begin
    bit startReq, full, walk;
    entry_t ne;
    if (!rstN) begin
      mq.delete(); mNeeds = 0; mUpg = 0; mBusy = 0; mKindRew = 0;
      mDone = 0; mCp = 0; mOvf = 0; mIdx = 0; mCpOrder = 0;
    end else begin
      mDone = 0; mCp = 0; mOvf = 0;
      startReq = !mBusy && (rewriteStart || pendScanStart);
      if (mBusy) begin
        if (mKindRew) begin
          if (mq[mIdx].cmd == CMD_UPGRADE) mq[mIdx].cmd = CMD_READ_EX;
        end else begin
          mCp = mq[mIdx].mark; mCpOrder = mq[mIdx].order;
        end
        if (mIdx == mq.size() - 1) begin
          mBusy = 0; mDone = 1;
          if (mKindRew) mUpg = 0;
        end else mIdx++;
      end else if (startReq) begin
        mIdx = 0; mKindRew = rewriteStart;
        walk = rewriteStart ? (mUpg && mq.size() != 0) : (mq.size() != 0);
        if (walk) mBusy = 1;
        else begin
          mDone = 1;
          if (rewriteStart) mUpg = 0;
        end
      end else begin
        full = (mq.size() == DEPTH);
        if (popValid && mq.size() != 0) void'(mq.pop_front());
        if (pushValid) begin
          if (full) mOvf = 1;
          else begin
            ne.cmd = cmd_e'(pushCmd); ne.src = src_e'(pushSrc); ne.order = pushOrder;
            ne.ready = pushReady; ne.mark = pushMark;
            mq.push_back(ne);
            if (pushSrc != 2'd1) begin
              if (pushCmd == 3'd1 || pushCmd == 3'd2 || pushCmd == 3'd3) mNeeds = 1;
              if (pushCmd == 3'd2) mUpg = 1;
            end
          end
        end
      end
      if (flagReset) begin mNeeds = 0; mUpg = 0; end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      chk(count == CNT_W'(mq.size()), "R5/R6 count", 32'(count), 32'(mq.size()));
      chk(headValid == (mq.size() != 0), "R5 headValid", 32'(headValid), 32'(mq.size() != 0));
      if (mq.size() != 0) begin
        chk(headCmd == mq[0].cmd, "R5/R8 headCmd", 32'(headCmd), 32'(mq[0].cmd));
        chk(headSrc == mq[0].src && headMark == mq[0].mark, "R5 headSrc/mark",
            {headSrc, headMark}, {mq[0].src, mq[0].mark});
        chk(headOrder == mq[0].order, "R5 headOrder", 32'(headOrder), 32'(mq[0].order));
        chk(headReady == mq[0].ready, "R5 headReady", headReady, mq[0].ready);
      end
      chk(needsExcl == mNeeds, "R1/R3/R4 needsExcl", 32'(needsExcl), 32'(mNeeds));
      chk(hasUpgrade == mUpg, "R2/R3/R4/R8 hasUpgrade", 32'(hasUpgrade), 32'(mUpg));
      chk(scanBusy == mBusy, "R8/R10 scanBusy", 32'(scanBusy), 32'(mBusy));
      chk(scanDone == mDone, "R7/R9 scanDone", 32'(scanDone), 32'(mDone));
      chk(clearPendValid == mCp, "R9 clearPendValid", 32'(clearPendValid), 32'(mCp));
      if (mCp) chk(clearPendOrder == mCpOrder, "R9 clearPendOrder", 32'(clearPendOrder), 32'(mCpOrder));
      chk(overflowErr == mOvf, "R6 overflowErr", 32'(overflowErr), 32'(mOvf));
      if (clearPendValid) seenOrders.push_back(clearPendOrder);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic push(input int cmd, input int src, input int ord, input int rdy, input bit mark);
    pushValid = 1; pushCmd = 3'(cmd); pushSrc = 2'(src); pushOrder = 16'(ord);
    pushReady = 32'(rdy); pushMark = mark;
    @(negedge clk);
    pushValid = 0;
  endtask

  task automatic pop();
    popValid = 1; @(negedge clk); popValid = 0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 40; i++) begin
      if (scanDone) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(count == 0 && !needsExcl && !hasUpgrade && !headValid, "R5 reset state",
        {count, needsExcl, hasUpgrade}, 0);

    push(0, 0, 10, 100, 0);
    chk(!needsExcl, "R1 read leaves needsExcl", 32'(needsExcl), 0);
    push(2, 1, 11, 101, 0);
    chk(!needsExcl && !hasUpgrade, "R3 snoop upgrade ignored", {needsExcl, hasUpgrade}, 0);
    push(1, 2, 12, 102, 1);
    chk(needsExcl && !hasUpgrade, "R1/R2 prefetch read-exclusive", {needsExcl, hasUpgrade}, 2);
    push(2, 0, 13, 103, 1);
    chk(hasUpgrade, "R2 cpu upgrade sets flag", 32'(hasUpgrade), 1);

    // rewrite walk, with a push attempted while busy
    rewriteStart = 1; @(negedge clk); rewriteStart = 0;
    chk(scanBusy, "R8 rewrite busy", 32'(scanBusy), 1);
    push(0, 0, 99, 999, 0);
    waitDone();
    @(negedge clk);
    chk(!hasUpgrade && count == 4, "R8/R10 after rewrite", {hasUpgrade, count}, 4);

    // pending release walk
    seenOrders.delete();
    pendScanStart = 1; @(negedge clk); pendScanStart = 0;
    waitDone();
    @(negedge clk);
    chk(seenOrders.size() == 2, "R9 pulse count", seenOrders.size(), 2);
    if (seenOrders.size() == 2)
      chk(seenOrders[0] == 12 && seenOrders[1] == 13, "R9 pulse orders",
          {seenOrders[0], seenOrders[1]}, {16'd12, 16'd13});

    // rewrite with no upgrade present
    rewriteStart = 1; @(negedge clk); rewriteStart = 0;
    chk(scanDone && !scanBusy, "R7 no-op rewrite", {scanDone, scanBusy}, 2);

    flagReset = 1; @(negedge clk); flagReset = 0;
    chk(!needsExcl && !hasUpgrade, "R4 flag reset", {needsExcl, hasUpgrade}, 0);

    chk(headOrder == 10, "R5 head first", 32'(headOrder), 10);
    pop();
    chk(headCmd == 3'd1, "R8 snoop upgrade rewritten", 32'(headCmd), 1);
    repeat (3) pop();
    pop();
    chk(count == 0, "R6 pop empty ignored", 32'(count), 0);

    for (int i = 0; i < DEPTH; i++) push(2, 0, 200 + i, 5000 + i, i[0]);
    push(0, 0, 300, 0, 0);
    chk(overflowErr && count == DEPTH, "R6 overflow refused", {overflowErr, count}, {1'b1, 4'(DEPTH)});
    @(negedge clk);
    chk(!overflowErr, "R6 overflow one cycle", 32'(overflowErr), 0);

    // both starts together: rewrite wins
    seenOrders.delete();
    rewriteStart = 1; pendScanStart = 1; popValid = 1;
    @(negedge clk);
    rewriteStart = 0; pendScanStart = 0; popValid = 0;
    waitDone();
    @(negedge clk);
    chk(seenOrders.size() == 0 && !hasUpgrade && count == DEPTH, "R10 rewrite priority",
        {seenOrders.size(), hasUpgrade, count}, DEPTH);
    chk(headCmd == 3'd1, "R8 all upgrades rewritten", 32'(headCmd), 1);

    // random traffic, model compared every cycle
    for (int c = 0; c < 4000; c++) begin
      pushValid = ($urandom_range(0, 99) < 50);
      pushCmd = 3'($urandom_range(0, 4));
      pushSrc = 2'($urandom_range(0, 2));
      pushOrder = 16'($urandom);
      pushReady = $urandom;
      pushMark = $urandom_range(0, 1);
      popValid = ($urandom_range(0, 99) < 40);
      flagReset = ($urandom_range(0, 99) < 3);
      rewriteStart = ($urandom_range(0, 99) < 4);
      pendScanStart = ($urandom_range(0, 99) < 4);
      @(negedge clk);
    end
    pushValid = 0; popValid = 0; flagReset = 0; rewriteStart = 0; pendScanStart = 0;
    repeat (20) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule